// File: doc/BRIEF.md
# Row-Hit-First Bank Request Scheduler

This block holds the pending read and write requests for a single DRAM bank and decides which one the command sequencer should serve next. Each request carries a row, a column and a tag. The sequencer supplies the row that is currently open in the bank, together with a flag that says whether any row is open. It pulses a grant to take the request that the block is presenting.

By default the block serves row hits first. Any queued request whose row matches the open row wins over requests to other rows. Within the winning group, the request that arrived earliest is chosen. Because of this, a younger row hit can overtake an older request that would need a row change. A policy input switches the block to strict arrival order.

Age is kept as a pairwise ordering matrix across the slots, so the oldest member of any candidate set is found exactly, with no counter that can wrap. The presented request is decoded combinationally from the queued state and the current open-row inputs. A change of open row therefore takes effect on the very next selection.

Top module: `dram_rowhit_sched`

## Requirements
- R1: After reset the queue is empty: `sel_valid` is 0 and `enq_ready` is 1.
- R2: With `oldest_mode` = 1, the presented request is always the one queued earliest among all entries.
- R3: With `oldest_mode` = 0 and `open_row_vld` = 1, a queued request whose row equals `open_row` is presented in preference to any request to another row, even an older one.
- R4: With `oldest_mode` = 0 and several row hits queued, the earliest-arrived hit is presented.
- R5: With `oldest_mode` = 0 and no row hit queued, the earliest-arrived request is presented.
- R6: While `open_row_vld` = 0, no request counts as a hit: `sel_hit` is 0 and selection follows arrival order.
- R7: `enq_ready` is 0 exactly when the queue holds DEPTH entries, and an enqueue offered while the queue is full is dropped.
- R8: An enqueue and a grant in the same cycle are both carried out: the presented request leaves the queue and the new request joins it as the youngest.
- R9: A grant while `sel_valid` = 1 removes the presented request at the clock edge. A grant while the queue is empty has no effect.
- R10: With row 0 open and (row 0, col 0), (row 1, col 10), (row 0, col 1) enqueued in that order, row-hit-first mode serves them in the order first, third, second. Oldest-first mode serves them in arrival order.
- R11: `sel_hit` is 1 exactly when `sel_valid` = 1, `open_row_vld` = 1 and the presented row equals `open_row`. This holds in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| enq_valid | input | 1 | Offer a new request |
| enq_ready | output | 1 | Queue can accept a request this cycle |
| enq_row | input | ROW_W | Row of the new request |
| enq_col | input | COL_W | Column of the new request |
| enq_tag | input | TAG_W | Tag of the new request |
| open_row | input | ROW_W | Row currently open in the bank |
| open_row_vld | input | 1 | A row is open |
| oldest_mode | input | 1 | 1 selects strict arrival order, 0 selects row-hit-first |
| grant | input | 1 | Sequencer takes the presented request |
| sel_valid | output | 1 | A request is presented |
| sel_row | output | ROW_W | Row of the presented request |
| sel_col | output | COL_W | Column of the presented request |
| sel_tag | output | TAG_W | Tag of the presented request |
| sel_hit | output | 1 | Presented request targets the open row |

## Verification
The bench uses only four rows, so hits, misses and ties are all frequent. Its reference model keeps the queue as a list in arrival order and compares every presented tag against that model, cycle by cycle, across long pseudo-random runs in both modes with the open row changing as the run goes on.

Each of the following faults shows up as a wrong tag: an age order that is lost when a slot is reused, a hit that is detected while no row is open, or a policy that ignores the mode. A queue that accepts an enqueue while full, or that loses one side of a simultaneous grant and enqueue, drifts away from the model and is caught at the next presentation or by a wrong `enq_ready`. The three-request example is also run explicitly in both modes.

// File: rtl/rq_pkg.sv
package rq_pkg;
  // Encoding of the policy input: value 1 means strict arrival order
  typedef enum logic {
    POL_ROWHIT = 1'b0,
    POL_OLDEST = 1'b1
  } policy_e;
endpackage

// File: rtl/rq_slots.sv
module rq_slots #(
  parameter int DEPTH = 8,
  parameter int ROW_W = 4,
  parameter int COL_W = 4,
  parameter int TAG_W = 4,
  parameter int IDX_W = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         enq_acc,
  input  logic [ROW_W-1:0]             enq_row,
  input  logic [COL_W-1:0]             enq_col,
  input  logic [TAG_W-1:0]             enq_tag,
  input  logic                         deq_acc,
  input  logic [IDX_W-1:0]             deq_idx,
  output logic [DEPTH-1:0]             valid,
  output logic [DEPTH-1:0][ROW_W-1:0]  rows,
  output logic [DEPTH-1:0][COL_W-1:0]  cols,
  output logic [DEPTH-1:0][TAG_W-1:0]  tags,
  output logic [IDX_W-1:0]             free_idx,
  output logic                         full
);
  logic [DEPTH-1:0] valid_q, valid_d;

  assign valid = valid_q;
  assign full  = &valid_q;

  // lowest free slot
  always_comb begin
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!valid_q[i]) free_idx = IDX_W'(i);
    end
  end

  always_comb begin
    valid_d = valid_q;
    if (deq_acc) valid_d[deq_idx] = 1'b0;
    if (enq_acc) valid_d[free_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else if (enq_acc || deq_acc) valid_q <= valid_d;
  end

  // payload storage, written only on accept
  always_ff @(posedge clk) begin
    if (enq_acc) begin
      rows[free_idx] <= enq_row;
      cols[free_idx] <= enq_col;
      tags[free_idx] <= enq_tag;
    end
  end

  // R7
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !deq_acc) |=> $stable(valid_q));

  // R8
  swap_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_acc && deq_acc) |=> ($countones(valid_q) == $past($countones(valid_q))));
endmodule

// File: rtl/rq_age.sv
module rq_age #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [DEPTH-1:0]             valid,
  input  logic                         enq_acc,
  input  logic [IDX_W-1:0]             enq_idx,
  input  logic                         deq_acc,
  input  logic [IDX_W-1:0]             deq_idx,
  output logic [DEPTH-1:0][DEPTH-1:0]  older
);
  // older[i][j] = 1: slot i arrived before slot j
  logic [DEPTH-1:0][DEPTH-1:0] older_q, older_d;

  assign older = older_q;

  always_comb begin
    older_d = older_q;
    if (enq_acc) begin
      for (int j = 0; j < DEPTH; j++) begin
        older_d[enq_idx][j] = 1'b0;
        older_d[j][enq_idx] = valid[j] && (IDX_W'(j) != enq_idx) &&
                              !(deq_acc && (deq_idx == IDX_W'(j)));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) older_q <= '0;
    else if (enq_acc) older_q <= older_d;
  end

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_row
      for (genvar j = i + 1; j < DEPTH; j++) begin : g_col
        // R2
        age_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
          (valid[i] && valid[j]) |-> (older_q[i][j] != older_q[j][i]));
      end
    end
  endgenerate
endmodule

// File: rtl/rq_pick.sv
module rq_pick #(
  parameter int DEPTH = 8,
  parameter int ROW_W = 4,
  parameter int IDX_W = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [DEPTH-1:0]             valid,
  input  logic [DEPTH-1:0][ROW_W-1:0]  rows,
  input  logic [DEPTH-1:0][DEPTH-1:0]  older,
  input  logic [ROW_W-1:0]             open_row,
  input  logic                         open_vld,
  input  rq_pkg::policy_e              policy,
  output logic                         sel_valid,
  output logic [IDX_W-1:0]             sel_idx,
  output logic                         sel_hit
);
  logic [DEPTH-1:0] hit, cand, win;
  logic             use_hit;

  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      hit[i] = valid[i] && open_vld && (rows[i] == open_row);
    use_hit = (policy == rq_pkg::POL_ROWHIT) && (|hit);
    cand    = use_hit ? hit : valid;
    for (int i = 0; i < DEPTH; i++) begin
      win[i] = cand[i];
      for (int j = 0; j < DEPTH; j++)
        if (cand[j] && older[j][i]) win[i] = 1'b0;
    end
    sel_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (win[i]) sel_idx = IDX_W'(i);
    sel_valid = |valid;
    sel_hit   = sel_valid && hit[sel_idx];
  end

  // R9
  win_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win) && (sel_valid == (|win)));

  // R11
  hit_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_hit |-> (open_vld && rows[sel_idx] == open_row && valid[sel_idx]));

  // R6
  closed_nohit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !open_vld |-> !sel_hit);

  generate
    for (genvar j = 0; j < DEPTH; j++) begin : g_old
      // R2
      oldest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (policy == rq_pkg::POL_OLDEST && sel_valid && valid[j]) |-> !older[j][sel_idx]);
      // R3
      hit_pref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (policy == rq_pkg::POL_ROWHIT && open_vld && valid[j] && rows[j] == open_row) |-> sel_hit);
    end
  endgenerate
endmodule

// File: rtl/dram_rowhit_sched.sv
module dram_rowhit_sched #(
  parameter int DEPTH = 8,
  parameter int ROW_W = 4,
  parameter int COL_W = 4,
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enq_valid,
  output logic             enq_ready,
  input  logic [ROW_W-1:0] enq_row,
  input  logic [COL_W-1:0] enq_col,
  input  logic [TAG_W-1:0] enq_tag,
  input  logic [ROW_W-1:0] open_row,
  input  logic             open_row_vld,
  input  logic             oldest_mode,
  input  logic             grant,
  output logic             sel_valid,
  output logic [ROW_W-1:0] sel_row,
  output logic [COL_W-1:0] sel_col,
  output logic [TAG_W-1:0] sel_tag,
  output logic             sel_hit
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [1:0] rst_sync;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  logic [DEPTH-1:0]            valid;
  logic [DEPTH-1:0][ROW_W-1:0] rows;
  logic [DEPTH-1:0][COL_W-1:0] cols;
  logic [DEPTH-1:0][TAG_W-1:0] tags;
  logic [DEPTH-1:0][DEPTH-1:0] older;
  logic [IDX_W-1:0]            free_idx, sel_idx;
  logic                        full, enq_acc, deq_acc;
  rq_pkg::policy_e             policy;

  assign policy    = oldest_mode ? rq_pkg::POL_OLDEST : rq_pkg::POL_ROWHIT;
  assign enq_ready = !full;
  assign enq_acc   = enq_valid && !full;
  assign deq_acc   = grant && sel_valid;

  rq_slots #(.DEPTH(DEPTH), .ROW_W(ROW_W), .COL_W(COL_W), .TAG_W(TAG_W), .IDX_W(IDX_W)) slots_i (
    .clk(clk), .rst_n(rst_s), .enq_acc(enq_acc), .enq_row(enq_row), .enq_col(enq_col),
    .enq_tag(enq_tag), .deq_acc(deq_acc), .deq_idx(sel_idx), .valid(valid), .rows(rows),
    .cols(cols), .tags(tags), .free_idx(free_idx), .full(full));

  rq_age #(.DEPTH(DEPTH), .IDX_W(IDX_W)) age_i (
    .clk(clk), .rst_n(rst_s), .valid(valid), .enq_acc(enq_acc), .enq_idx(free_idx),
    .deq_acc(deq_acc), .deq_idx(sel_idx), .older(older));

  rq_pick #(.DEPTH(DEPTH), .ROW_W(ROW_W), .IDX_W(IDX_W)) pick_i (
    .clk(clk), .rst_n(rst_s), .valid(valid), .rows(rows), .older(older),
    .open_row(open_row), .open_vld(open_row_vld), .policy(policy),
    .sel_valid(sel_valid), .sel_idx(sel_idx), .sel_hit(sel_hit));

  assign sel_row = rows[sel_idx];
  assign sel_col = cols[sel_idx];
  assign sel_tag = tags[sel_idx];

  // R1
  reset_empty_chk: assert property (@(posedge clk)
    !rst_s |=> (!sel_valid && enq_ready));
endmodule

// File: tb/dram_rowhit_sched_tb_top.sv
module dram_rowhit_sched_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enq_valid = 1'b0, open_row_vld = 1'b0, oldest_mode = 1'b0, grant = 1'b0;
  logic [W-1:0] enq_row = '0, enq_col = '0, enq_tag = '0, open_row = '0;
  logic enq_ready, sel_valid, sel_hit;
  logic [W-1:0] sel_row, sel_col, sel_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_rowhit_sched #(.DEPTH(DEPTH), .ROW_W(W), .COL_W(W), .TAG_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_ready(enq_ready),
    .enq_row(enq_row), .enq_col(enq_col), .enq_tag(enq_tag), .open_row(open_row),
    .open_row_vld(open_row_vld), .oldest_mode(oldest_mode), .grant(grant),
    .sel_valid(sel_valid), .sel_row(sel_row), .sel_col(sel_col), .sel_tag(sel_tag),
    .sel_hit(sel_hit));

  int errors = 0, checks = 0;
  bit done = 0;
  // reference queue, index 0 = oldest
  logic [W-1:0] m_row [DEPTH];
  logic [W-1:0] m_tag [DEPTH];
  int cnt = 0;
  bit prev_both = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [W-1:0] tag_ctr = '0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int pick();
    if (!oldest_mode && open_row_vld)
      for (int i = 0; i < cnt; i++)
        if (m_row[i] == open_row) return i;
    return 0;
  endfunction

  function automatic bit any_hit();
    for (int i = 0; i < cnt; i++)
      if (open_row_vld && m_row[i] == open_row) return 1;
    return 0;
  endfunction

  // called just after a negedge with inputs already driven
  task automatic step();
    int idx;
    string lbl;
    bit eacc, gacc;
    #1;
    check(sel_valid == (cnt > 0), prev_both ? "R8" : "R9", sel_valid, cnt > 0);
    check(enq_ready == (cnt < DEPTH), "R7", enq_ready, cnt < DEPTH);
    idx = pick();
    if (cnt > 0) begin
      if (oldest_mode) lbl = "R2";
      else if (!open_row_vld) lbl = "R6";
      else if (!any_hit()) lbl = "R5";
      else if (idx != 0) lbl = "R3";
      else lbl = "R4";
      check(sel_tag == m_tag[idx], lbl, sel_tag, m_tag[idx]);
      check(sel_hit == (open_row_vld && m_row[idx] == open_row), "R11", sel_hit,
            open_row_vld && m_row[idx] == open_row);
    end else begin
      check(sel_hit == 1'b0, "R11", sel_hit, 0);
    end
    eacc = enq_valid && (cnt < DEPTH);
    gacc = grant && (cnt > 0);
    prev_both = eacc && gacc;
    @(posedge clk);
    if (gacc) begin
      for (int i = idx; i < cnt - 1; i++) begin
        m_row[i] = m_row[i+1];
        m_tag[i] = m_tag[i+1];
      end
      cnt--;
    end
    if (eacc) begin
      m_row[cnt] = enq_row;
      m_tag[cnt] = enq_tag;
      cnt++;
    end
    @(negedge clk);
  endtask

  task automatic push_only(input logic [W-1:0] r, input logic [W-1:0] c, input logic [W-1:0] t);
    enq_valid = 1; enq_row = r; enq_col = c; enq_tag = t; grant = 0;
    step();
    enq_valid = 0;
  endtask

  task automatic pop_expect(input logic [W-1:0] t, input string req);
    grant = 1; enq_valid = 0;
    #1;
    check(sel_valid && sel_tag == t, req, sel_tag, t);
    #(-1 + 1);
    step();
    grant = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    cnt = 0; prev_both = 0;
    enq_valid = 0; grant = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    #1;
    check(sel_valid == 0, "R1", sel_valid, 0);
    check(enq_ready == 1, "R1", enq_ready, 1);
    @(negedge clk);
  endtask

  function automatic logic [15:0] nxt(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R10 row-hit-first order on the three-request example
    do_reset();
    oldest_mode = 0; open_row = 0; open_row_vld = 1;
    push_only(0, 0, 1);
    push_only(1, 10, 2);
    push_only(0, 1, 3);
    pop_expect(1, "R10");
    pop_expect(3, "R10");
    open_row = 1;
    pop_expect(2, "R10");
    // R10 oldest-first order
    do_reset();
    oldest_mode = 1; open_row = 0; open_row_vld = 1;
    push_only(0, 0, 1);
    push_only(1, 10, 2);
    push_only(0, 1, 3);
    pop_expect(1, "R10");
    pop_expect(2, "R10");
    pop_expect(3, "R10");
    // R7 fill beyond capacity, then R9 drain and grant on empty
    do_reset();
    oldest_mode = 1; open_row_vld = 0;
    for (int k = 0; k < DEPTH + 2; k++) push_only(W'(k % 4), W'(k), W'(k));
    for (int k = 0; k < DEPTH + 2; k++) begin
      grant = 1; step();
    end
    grant = 0;
    // pseudo-random sweeps in each policy and open-row pattern
    for (int ph = 0; ph < 8; ph++) begin
      do_reset();
      oldest_mode = ph[0];
      for (int c = 0; c < 2500; c++) begin
        lfsr = nxt(lfsr);
        enq_valid = (lfsr[2:0] < (ph[1] ? 3'd6 : 3'd4));
        grant = (lfsr[5:3] < (ph[1] ? 3'd3 : 3'd5));
        enq_row = W'(lfsr[7:6]);
        enq_col = W'(lfsr[11:8]);
        enq_tag = tag_ctr;
        if (enq_valid && cnt < DEPTH) tag_ctr = tag_ctr + 1'b1;
        if (lfsr[14:12] == 3'd0) open_row = W'(lfsr[9:8]);
        open_row_vld = ph[2] ? (lfsr[15] | lfsr[1]) : 1'b1;
        step();
      end
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule